// File: doc/BRIEF.md
# Synchronous Serial Word Transmitter

This block sends 16-bit words on a serial data pin together with a serial clock pin that it drives itself. Software writes a word into a one-entry holding buffer. While the transmitter is enabled, the word is moved into a shift register and sent most significant bit first. The output clock comes from a programmable divider of the system clock. Both pins are driven only while a word is being sent. At all other times their output enables are low, and external pull-ups set the line level.

A disable request acts only at a word boundary: the word in flight always completes. If enable returns before that boundary, nothing changes on the wire. With enable held and the buffer refilled in time, words follow one another with no gap. In autotransmit mode the stream keeps going on buffer contents alone and stops when the buffer runs empty. A write to a full buffer is dropped and reported by a one-cycle overrun pulse.

Top module: `sst_tx_top`

## Requirements
- R1: A word goes out as 16 bits, bit 15 first and bit 0 last. `sdo` changes only together with a falling `sck` and is stable while `sck` is high. A receiver samples it on the rising `sck`.
- R2: The internal baud clock toggles once every `div_val`+1 system clocks. Inside a burst, consecutive rising edges of `sck` are therefore 2·(`div_val`+1) system clocks apart.
- R3: When the unit is idle, `tx_en` is 1 and the buffer is full, sending starts at the next falling baud edge. The pins are enabled with `sck` low and bit 15 already on `sdo`, and the buffer is emptied. With an empty buffer, `tx_en` starts nothing.
- R4: If `tx_en` drops while a word is being shifted, all 16 bits of that word are still sent. The stop happens at a falling baud edge.
- R5: A stop caused by a disable leaves a waiting buffer word in the buffer (`buf_empty` stays 0) and does not send it until a later enable.
- R6: If `tx_en` is dropped and raised again before the current word ends, the next buffered word follows with no gap. The result is the same as if enable had stayed high.
- R7: With `auto_mode` = 0 and `tx_en` held high, a word end reloads from a full buffer back-to-back. If the buffer is empty, the unit stops.
- R8: With `auto_mode` = 1, a word end reloads from a full buffer whatever the level of `tx_en`. The stream stops at the first word end that finds the buffer empty.
- R9: While the unit is not sending, `sdo_oe` and `sck_oe` are both 0.
- R10: `busy` is 1 from the cycle the first bit is driven until the cycle the pins are released, and equals `sdo_oe`.
- R11: A write (`wr_valid` = 1) to a full buffer is ignored, and `overrun` is 1 for exactly the following cycle. A write to an empty buffer fills it and causes no overrun.
- R12: After reset both output enables are 0, `busy` is 0, `buf_empty` is 1 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Baud divider: one baud toggle every div_val+1 clocks |
| tx_en | input | 1 | Transmitter enable |
| auto_mode | input | 1 | 1 = autotransmit: continue on buffer contents alone |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | WORD_W | Word to be written |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable of the data pin |
| sck | output | 1 | Serial clock value |
| sck_oe | output | 1 | Output enable of the clock pin |
| busy | output | 1 | Word transfer in progress |
| buf_empty | output | 1 | Holding buffer is empty |
| overrun | output | 1 | One-cycle pulse: a write to a full buffer was dropped |

## Verification
The assertions check on every cycle the local rules at the pins. The pins always turn on with a low clock and an already emptied buffer. Data holds while the clock is high. Pins are released only right after a high clock phase. The overrun pulse follows a write to a full buffer and nothing else. The bench scenarios are needed for everything that only shows over a whole word or a sequence of words: the bit order, the word count after a disable, the seamless re-enable, the waiting word that a disable leaves unsent, the stop of an autotransmit stream when the buffer runs dry, and the gap-free bit spacing for each divider value.

// File: rtl/sst_pkg.sv
package sst_pkg;
  parameter int unsigned SST_WORD_W = 16;
  parameter int unsigned SST_DIV_W  = 8;
endpackage

// File: rtl/sst_baud_gen.sv
module sst_baud_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             bclk
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_d;

  always_comb begin
    tick   = (cnt_q >= div_val);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    bclk_d = tick ? ~bclk : bclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bclk  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      bclk  <= bclk_d;
    end
  end
endmodule

// File: rtl/sst_hold_buf.sv
module sst_hold_buf #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic [WORD_W-1:0] buf_q,
  output logic              full,
  output logic              overrun
);
  logic [WORD_W-1:0] buf_d;
  logic              full_d, ovr_d, accept;

  always_comb begin
    accept = wr_valid && !full;
    ovr_d  = wr_valid && full;
    buf_d  = accept ? wr_data : buf_q;
    if (accept)    full_d = 1'b1;
    else if (take) full_d = 1'b0;
    else           full_d = full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (accept) buf_q <= buf_d;
      full    <= full_d;
      overrun <= ovr_d;
    end
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bclk,
  input  logic              tx_en,
  input  logic              auto_mode,
  input  logic              buf_full,
  input  logic [WORD_W-1:0] buf_q,
  output logic              take,
  output logic              active,
  output logic              sdo
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              act_d;
  logic              fall_edge, start, word_end, carry_on;

  always_comb begin
    fall_edge = tick && bclk;
    start     = !active && fall_edge && tx_en && buf_full;
    word_end  = active && fall_edge && (bit_q == LAST_BIT);
    carry_on  = buf_full && (auto_mode || tx_en);
    take      = start || (word_end && carry_on);
    sh_d      = sh_q;
    bit_d     = bit_q;
    act_d     = active;
    if (take) begin
      sh_d  = buf_q;
      bit_d = '0;
      act_d = 1'b1;
    end else if (word_end) begin
      act_d = 1'b0;
    end else if (active && fall_edge) begin
      sh_d  = {sh_q[WORD_W-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      active <= 1'b0;
    end else if (fall_edge) begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      active <= act_d;
    end
  end

  assign sdo = sh_q[WORD_W-1];
endmodule

// File: rtl/sst_tx_top.sv
module sst_tx_top #(
  parameter int unsigned WORD_W = sst_pkg::SST_WORD_W,
  parameter int unsigned DIV_W  = sst_pkg::SST_DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tx_en,
  input  logic              auto_mode,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sck,
  output logic              sck_oe,
  output logic              busy,
  output logic              buf_empty,
  output logic              overrun
);
  logic              tick, bclk, take, full, active, sh_out;
  logic [WORD_W-1:0] buf_q;

  sst_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .tick(tick), .bclk(bclk)
  );

  sst_hold_buf #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(take), .buf_q(buf_q), .full(full), .overrun(overrun)
  );

  sst_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bclk(bclk), .tx_en(tx_en),
    .auto_mode(auto_mode), .buf_full(full), .buf_q(buf_q), .take(take),
    .active(active), .sdo(sh_out)
  );

  assign sdo       = sh_out;
  assign sdo_oe    = active;
  assign sck       = bclk;
  assign sck_oe    = active;
  assign busy      = active;
  assign buf_empty = !full;
endmodule

// File: rtl/sst_tx_checker.sv
module sst_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_valid,
  input logic sdo,
  input logic sdo_oe,
  input logic sck,
  input logic buf_empty,
  input logic overrun
);
  AST_START_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (!sck && buf_empty && $past(tx_en))); // R3

  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && sck && $past(sck)) |-> $stable(sdo)); // R1

  AST_STOP_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> ($past(sck) && !sck)); // R4

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !buf_empty) |=> overrun); // R11

  AST_OVERRUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && !buf_empty) |=> !overrun); // R11

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && buf_empty) |=> !buf_empty); // R11
endmodule

bind sst_tx_top sst_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
  .sdo(sdo), .sdo_oe(sdo_oe), .sck(sck), .buf_empty(buf_empty),
  .overrun(overrun)
);

// File: tb/sst_tx_top_test.sv
module sst_tx_top_test;
  logic        clk, rst_n, tx_en, auto_mode, wr_valid;
  logic [7:0]  div_val;
  logic [15:0] wr_data;
  logic        sdo, sdo_oe, sck, sck_oe, busy, buf_empty, overrun;

  int n_chk, n_fail, cyc, period, gap_err, busy_err, rx_n, bits;
  logic [15:0] rx_w [0:63];
  logic [15:0] rx_sh;
  logic        prev_sck, cont;
  int          last_t;
  bit          done;

  sst_tx_top uut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .tx_en(tx_en),
    .auto_mode(auto_mode), .wr_valid(wr_valid), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .sck(sck), .sck_oe(sck_oe), .busy(busy),
    .buf_empty(buf_empty), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_period(input int d);
    return 2 * (d + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // receiver model: capture on rising sck while driven
  always @(negedge clk) begin
    cyc++;
    if (busy !== sdo_oe || sck_oe !== sdo_oe) busy_err++;
    if (sdo_oe && sck_oe) begin
      if (sck && !prev_sck) begin
        if (cont && (cyc - last_t) != period) gap_err++;
        last_t = cyc;
        cont   = 1'b1;
        rx_sh  = {rx_sh[14:0], sdo};
        bits++;
        if (bits == 16) begin
          if (rx_n < 64) rx_w[rx_n] = rx_sh;
          rx_n++;
          bits = 0;
        end
      end
    end else begin
      cont = 1'b0;
      bits = 0;
    end
    prev_sck = sck;
  end

  task automatic wr(input logic [15:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_busy();
    while (!busy) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_div();
    div_val = 8'($urandom_range(1, 4));
    period  = exp_period(int'(div_val));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] wa, wb, wc;
    logic [15:0] aw [0:5];
    int base;
    void'($urandom(32'h5eed_0042));
    n_chk = 0; n_fail = 0; cyc = 0; gap_err = 0; busy_err = 0;
    rx_n = 0; bits = 0; rx_sh = '0; prev_sck = 1'b1; cont = 1'b0; last_t = 0;
    done = 1'b0;
    rst_n = 1'b0; tx_en = 1'b0; auto_mode = 1'b0; wr_valid = 1'b0; wr_data = '0;
    div_val = 8'd2; period = exp_period(2);
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!sdo_oe && !sck_oe && !busy && buf_empty && !overrun, "R12 reset",
          {sdo_oe, sck_oe, busy, buf_empty, overrun}, 5'b00010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 enable with empty buffer starts nothing
    tx_en = 1'b1;
    repeat (40) @(negedge clk);
    check(!busy && !sdo_oe, "R3 empty buffer no start", busy, 0);
    tx_en = 1'b0;

    // single word: disable right after start (R1 R3 R4 R9)
    set_div();
    wa = 16'($urandom);
    base = rx_n;
    wr(wa);
    check(!overrun && !buf_empty, "R11 write empty no overrun", overrun, 0);
    tx_en = 1'b1;
    wait_busy();
    check(buf_empty && !sck, "R3 buffer taken, clock low", {buf_empty, sck}, 2'b10);
    tx_en = 1'b0;
    wait_idle();
    @(negedge clk);
    check(rx_n - base == 1, "R4 word completes after disable", rx_n - base, 1);
    check(rx_w[base] == wa, "R1 msb first word", rx_w[base], wa);
    check(!sdo_oe && !sck_oe, "R9 released when idle", {sdo_oe, sck_oe}, 0);

    // R7 enable held, two words, stop on empty
    set_div();
    wa = 16'($urandom); wb = 16'($urandom);
    base = rx_n;
    wr(wa);
    tx_en = 1'b1;
    wait_busy();
    wr(wb);
    wait_idle();
    @(negedge clk);
    check(rx_n - base == 2, "R7 back-to-back count", rx_n - base, 2);
    check(rx_w[base] == wa && rx_w[base+1] == wb, "R7 words", rx_w[base+1], wb);
    check(buf_empty, "R7 stopped on empty", buf_empty, 1);
    tx_en = 1'b0;

    // R6 drop and re-raise mid word
    set_div();
    wa = 16'($urandom); wb = 16'($urandom);
    base = rx_n; gap_err = 0;
    wr(wa);
    tx_en = 1'b1;
    wait_busy();
    wr(wb);
    tx_en = 1'b0;
    repeat (period * 3) @(negedge clk);
    tx_en = 1'b1;
    wait_idle();
    tx_en = 1'b0;
    @(negedge clk);
    check(rx_n - base == 2 && rx_w[base+1] == wb, "R6 seamless re-enable",
          rx_n - base, 2);
    check(gap_err == 0, "R6 R2 no gap, bit spacing", gap_err, 0);

    // R5 disable leaves buffer word waiting
    set_div();
    wa = 16'($urandom); wb = 16'($urandom);
    base = rx_n;
    wr(wa);
    tx_en = 1'b1;
    wait_busy();
    wr(wb);
    tx_en = 1'b0;
    wait_idle();
    repeat (period * 20) @(negedge clk);
    check(rx_n - base == 1, "R4 only in-flight word sent", rx_n - base, 1);
    check(!buf_empty && !busy, "R5 buffer not loaded", buf_empty, 0);
    tx_en = 1'b1;
    wait_busy();
    tx_en = 1'b0;
    wait_idle();
    @(negedge clk);
    check(rx_n - base == 2 && rx_w[base+1] == wb, "R5 waiting word later sent",
          rx_w[base+1], wb);

    // R11 overrun
    wa = 16'($urandom); wb = ~wa;
    base = rx_n;
    wr(wa);
    wr(wb);
    check(overrun, "R11 overrun pulse", overrun, 1);
    @(negedge clk);
    check(!overrun, "R11 overrun one cycle", overrun, 0);
    tx_en = 1'b1;
    wait_busy();
    tx_en = 1'b0;
    wait_idle();
    @(negedge clk);
    check(rx_n - base == 1 && rx_w[base] == wa, "R11 dropped write ignored",
          rx_w[base], wa);

    // R8 autotransmit with enable removed
    set_div();
    auto_mode = 1'b1;
    base = rx_n; gap_err = 0;
    for (int i = 0; i < 6; i++) aw[i] = 16'($urandom);
    wr(aw[0]);
    tx_en = 1'b1;
    wait_busy();
    tx_en = 1'b0;
    for (int i = 1; i < 6; i++) begin
      while (!buf_empty) @(negedge clk);
      wr(aw[i]);
    end
    wait_idle();
    @(negedge clk);
    check(rx_n - base == 6, "R8 auto stream count", rx_n - base, 6);
    for (int i = 0; i < 6; i++)
      check(rx_w[base+i] == aw[i], "R8 auto word", rx_w[base+i], aw[i]);
    check(gap_err == 0, "R8 R2 auto no gap", gap_err, 0);
    check(!sdo_oe && buf_empty, "R8 stops when empty", sdo_oe, 0);
    auto_mode = 1'b0;

    check(busy_err == 0, "R10 busy tracks pin enables", busy_err, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule